// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

A single-channel DMA engine for an I/O peripheral. When the peripheral raises its request line, the engine asks a host for the bus with an active-low request/grant handshake. Once the grant arrives it runs transfers. Each transfer lasts one clock. During that clock the engine asserts the channel acknowledge, pulls one active-low I/O strobe (read or write) and presents the current address.

A 16-bit address counter steps up by one per transfer. A 16-bit transfer counter steps down by one per transfer. Both are loaded through a small write port while the engine is idle. Three modes decide when a bus tenure ends:
- Single mode releases the bus after one transfer.
- Block mode runs until terminal count.
- Demand mode runs until terminal count or until the peripheral drops its request. The count and address are kept, so work resumes from where it stopped.

Terminal count fires on the transfer that takes the counter from zero to all ones. It then latches a done flag. The flag blocks new requests until the count is reloaded.

Top module: `dma_chan_seq`

## Requirements
- R1: A write with `cfg_sel_i`=0 sets the mode from bits [1:0] (00 single, 01 block, 10 demand, 11 handled as single) and the direction from bit 2 (0: I/O read on `ior_no`, 1: I/O write on `iow_no`). `cfg_sel_i`=1 loads the count and `cfg_sel_i`=2 loads the address. Writes are taken only while the bus is neither requested nor held; otherwise they are ignored.
- R2: A request while idle and not done drives `hold_req_no` low. Transfers start only after `hold_ack_ni` goes low. After a tenure `hold_req_no` returns high, and the engine waits for `hold_ack_ni` high before it can request again.
- R3: Each transfer is one clock with `dack_o` high, exactly one strobe low as chosen by the direction, and `addr_o` showing the current address. The address then increments by one, wrapping from all ones to zero.
- R4: A loaded count N yields exactly N+1 transfers before terminal count; the count decrements by one per transfer.
- R5: `tc_o` is high during the transfer in which the count moves from 0 to all ones, and `done_o` is set from the next clock.
- R6: Single mode performs exactly one transfer per bus tenure.
- R7: Block mode transfers back to back until terminal count, whatever the request does after the start.
- R8: Demand mode continues while `dreq_i` is high at the end of each transfer. It stops on terminal count or on a low request. When stopped by the request, the count and address are kept, and transfers resume from them in a later tenure.
- R9: While `done_o` is high, requests raise no bus request. Writing the count clears `done_o`.
- R10: After reset: no bus request, no acknowledge, both strobes high, `tc_o` and `done_o` low, address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Programming write strobe |
| cfg_sel_i | input | 2 | Programming target: 0 mode, 1 count, 2 address |
| cfg_wdata_i | input | 16 | Programming write data |
| dreq_i | input | 1 | Peripheral transfer request |
| hold_ack_ni | input | 1 | Bus grant from host, active low |
| hold_req_no | output | 1 | Bus request to host, active low |
| dack_o | output | 1 | Channel acknowledge, high during a transfer |
| ior_no | output | 1 | I/O read strobe, active low |
| iow_no | output | 1 | I/O write strobe, active low |
| addr_o | output | 16 | Transfer address |
| tc_o | output | 1 | Terminal count pulse |
| done_o | output | 1 | Terminal count reached, requests blocked |

## Verification
In demand mode, terminal count and request removal can land on the same transfer. Both end the tenure, but only terminal count may set the done flag. The bench provokes this by loading a count of zero in demand mode and dropping the request during that single transfer. It then expects one transfer, one terminal-count pulse, done set, and no further bus request while the request is raised again. It also reloads the count with the request held high and expects transfers to resume at the preserved address.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_BLOCK  = 2'd1,
    MODE_DEMAND = 2'd2,
    MODE_RSVD   = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_XFER = 2'd2,
    ST_REL  = 2'd3
  } seq_state_e;

  localparam int unsigned CFG_SEL_W = 2;
  localparam logic [CFG_SEL_W-1:0] CFG_MODE  = 2'd0;
  localparam logic [CFG_SEL_W-1:0] CFG_COUNT = 2'd1;
  localparam logic [CFG_SEL_W-1:0] CFG_ADDR  = 2'd2;
endpackage

// File: rtl/dma_seq_cfg.sv
module dma_seq_cfg
  import dma_seq_pkg::*;
#(
  parameter int unsigned CFG_W  = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CFG_SEL_W-1:0] sel_i,
  input  logic [CFG_W-1:0]     wdata_i,
  input  logic                 idle_i,
  input  logic                 step_i,
  output xfer_mode_e           mode_o,
  output logic                 dir_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 cnt_zero_o,
  output logic                 done_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  xfer_mode_e        mode_q;
  logic              dir_q;
  logic              done_q;
  logic              wr_ok;

  // programming only between tenures
  assign wr_ok = we_i && idle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_SINGLE;
      dir_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      if (wr_ok) begin
        case (sel_i)
          CFG_MODE: begin
            mode_q <= xfer_mode_e'(wdata_i[1:0]);
            dir_q  <= wdata_i[2];
          end
          CFG_COUNT: cnt_q  <= wdata_i[CNT_W-1:0];
          CFG_ADDR:  addr_q <= wdata_i[ADDR_W-1:0];
          default: ;
        endcase
      end
      if (step_i) begin
        cnt_q  <= cnt_q - 1'b1;
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             done_q <= 1'b0;
    else if (wr_ok && sel_i == CFG_COUNT)    done_q <= 1'b0;
    else if (step_i && cnt_q == '0)          done_q <= 1'b1;
  end

  assign mode_o     = mode_q;
  assign dir_o      = dir_q;
  assign addr_o     = addr_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign done_o     = done_q;
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  xfer_mode_e mode_i,
  input  logic       dreq_i,
  input  logic       hold_ack_ni,
  input  logic       done_i,
  input  logic       cnt_zero_i,
  output seq_state_e state_o,
  output logic       step_o,
  output logic       idle_o
);
  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (dreq_i && !done_i) st_d = ST_ARB;
      ST_ARB:  if (!hold_ack_ni)      st_d = ST_XFER;
      ST_XFER: begin
        if (cnt_zero_i) st_d = ST_REL;
        else begin
          unique case (mode_i)
            MODE_BLOCK:  st_d = ST_XFER;
            MODE_DEMAND: st_d = dreq_i ? ST_XFER : ST_REL;
            default:     st_d = ST_REL;
          endcase
        end
      end
      ST_REL:  if (hold_ack_ni) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign step_o  = (st_q == ST_XFER);
  assign idle_o  = (st_q == ST_IDLE);
endmodule

// File: rtl/dma_seq_drive.sv
module dma_seq_drive
  import dma_seq_pkg::*;
#(
  parameter bit STROBE_ACT_LOW = 1'b1
) (
  input  seq_state_e state_i,
  input  logic       dir_i,
  input  logic       cnt_zero_i,
  output logic       hold_req_no,
  output logic       dack_o,
  output logic       rd_o,
  output logic       wr_o,
  output logic       tc_o
);
  logic xfer;
  logic rd_act, wr_act;

  assign xfer        = (state_i == ST_XFER);
  assign hold_req_no = !(state_i == ST_ARB || xfer);
  assign dack_o      = xfer;
  assign rd_act      = xfer && !dir_i;
  assign wr_act      = xfer && dir_i;
  assign tc_o        = xfer && cnt_zero_i;

  generate
    if (STROBE_ACT_LOW) begin : g_low
      assign rd_o = !rd_act;
      assign wr_o = !wr_act;
    end else begin : g_high
      assign rd_o = rd_act;
      assign wr_o = wr_act;
    end
  endgenerate
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned CFG_W  = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_SEL_W-1:0] cfg_sel_i,
  input  logic [CFG_W-1:0]     cfg_wdata_i,
  input  logic                 dreq_i,
  input  logic                 hold_ack_ni,
  output logic                 hold_req_no,
  output logic                 dack_o,
  output logic                 ior_no,
  output logic                 iow_no,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 tc_o,
  output logic                 done_o
);
  xfer_mode_e mode_w;
  seq_state_e state_w;
  logic       dir_w, cnt_zero_w, step_w, idle_w;

  dma_seq_cfg #(.CFG_W(CFG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .idle_i     (idle_w),
    .step_i     (step_w),
    .mode_o     (mode_w),
    .dir_o      (dir_w),
    .addr_o     (addr_o),
    .cnt_zero_o (cnt_zero_w),
    .done_o     (done_o)
  );

  dma_seq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_w),
    .dreq_i      (dreq_i),
    .hold_ack_ni (hold_ack_ni),
    .done_i      (done_o),
    .cnt_zero_i  (cnt_zero_w),
    .state_o     (state_w),
    .step_o      (step_w),
    .idle_o      (idle_w)
  );

  dma_seq_drive #(.STROBE_ACT_LOW(1'b1)) u_drive (
    .state_i     (state_w),
    .dir_i       (dir_w),
    .cnt_zero_i  (cnt_zero_w),
    .hold_req_no (hold_req_no),
    .dack_o      (dack_o),
    .rd_o        (ior_no),
    .wr_o        (iow_no),
    .tc_o        (tc_o)
  );
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dreq_i,
  input logic              hold_ack_ni,
  input logic              hold_req_no,
  input logic              dack_o,
  input logic              ior_no,
  input logic              iow_no,
  input logic [ADDR_W-1:0] addr_o,
  input logic              tc_o,
  input logic              done_o,
  input xfer_mode_e        mode_i
);
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> (ior_no != iow_no));
  a_r3_strobe_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ior_no || !iow_no) |-> dack_o);
  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |=> (addr_o == ADDR_W'($past(addr_o) + 1'b1)));
  a_r2_bus_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> !hold_req_no);
  a_r2_grant_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dack_o) |-> $past(!hold_ack_ni));
  a_r5_tc_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> dack_o);
  a_r5_tc_sets_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> done_o);
  a_r6_single_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && mode_i != MODE_BLOCK && mode_i != MODE_DEMAND) |=> !dack_o);
  a_r7_block_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && mode_i == MODE_BLOCK && !tc_o) |=> dack_o);
  a_r8_demand_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && mode_i == MODE_DEMAND && !tc_o && dreq_i) |=> dack_o);
  a_r8_demand_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && mode_i == MODE_DEMAND && !dreq_i) |=> !dack_o);
  a_r9_done_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> hold_req_no);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dreq_i      (dreq_i),
  .hold_ack_ni (hold_ack_ni),
  .hold_req_no (hold_req_no),
  .dack_o      (dack_o),
  .ior_no      (ior_no),
  .iow_no      (iow_no),
  .addr_o      (addr_o),
  .tc_o        (tc_o),
  .done_o      (done_o),
  .mode_i      (mode_w)
);

// File: tb/dma_chan_seq_tb.sv
`timescale 1ns/1ps
module dma_chan_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  sel = '0;
  logic [15:0] wdata = '0;
  logic        dreq = 1'b0;
  logic        hack = 1'b1;
  logic        hreq, dack, ior_n, iow_n, tc, done;
  logic [15:0] addr;

  int n_chk = 0, n_bad = 0;
  int n_xfer = 0, n_rd = 0, n_wr = 0, n_tc = 0, n_ten = 0;
  logic [15:0] alog [64];
  logic prev_hreq = 1'b1;

  always #10 clk = ~clk;

  dma_chan_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_sel_i(sel),
    .cfg_wdata_i(wdata), .dreq_i(dreq), .hold_ack_ni(hack),
    .hold_req_no(hreq), .dack_o(dack), .ior_no(ior_n), .iow_no(iow_n),
    .addr_o(addr), .tc_o(tc), .done_o(done)
  );

  // host grants one clock after request, releases one clock after drop
  always @(posedge clk or negedge rst_n)
    if (!rst_n) hack <= 1'b1;
    else        hack <= hreq;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dack) begin
        if (n_xfer < 64) alog[n_xfer] = addr;
        n_xfer++;
        if (!ior_n) n_rd++;
        if (!iow_n) n_wr++;
      end
      if (tc) n_tc++;
      if (prev_hreq && !hreq) n_ten++;
      prev_hreq = hreq;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr();
    n_xfer = 0; n_rd = 0; n_wr = 0; n_tc = 0; n_ten = 0;
  endtask

  task automatic cfg_wr(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); we = 1'b1; sel = s; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_xfers(input int n);
    do begin @(negedge clk); #1; end while (n_xfer < n);
  endtask

  task automatic t_reset();
    chk("R10 hold_req", int'(hreq), 1);
    chk("R10 dack", int'(dack), 0);
    chk("R10 strobes", int'({ior_n, iow_n}), 3);
    chk("R10 tc", int'(tc), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 addr", int'(addr), 0);
  endtask

  task automatic t_single();
    cfg_wr(2'd0, 16'h0000);
    cfg_wr(2'd1, 16'd2);
    cfg_wr(2'd2, 16'h0100);
    clr();
    @(negedge clk); dreq = 1'b1;
    repeat (40) @(negedge clk);
    dreq = 1'b0;
    chk("R4 single count", n_xfer, 3);
    chk("R6 tenures", n_ten, 3);
    chk("R1 read strobes", n_rd, 3);
    chk("R1 no write", n_wr, 0);
    chk("R3 addr0", int'(alog[0]), 'h100);
    chk("R3 addr2", int'(alog[2]), 'h102);
    chk("R5 tc pulses", n_tc, 1);
    chk("R5 done", int'(done), 1);
    chk("R9 no request", int'(hreq), 1);
  endtask

  task automatic t_block();
    cfg_wr(2'd0, 16'h0005);
    cfg_wr(2'd1, 16'd4);
    cfg_wr(2'd2, 16'h0200);
    chk("R9 reload clears", int'(done), 0);
    clr();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    wait_xfers(1);
    cfg_wr(2'd1, 16'h0010); // busy: must be ignored
    repeat (30) @(negedge clk);
    chk("R7 block count", n_xfer, 5);
    chk("R7 one tenure", n_ten, 1);
    chk("R1 write strobes", n_wr, 5);
    chk("R1 no read", n_rd, 0);
    chk("R3 addr4", int'(alog[4]), 'h204);
    chk("R5 tc pulses", n_tc, 1);
    chk("R1 busy write ignored", int'(done), 1);
  endtask

  task automatic t_demand();
    cfg_wr(2'd0, 16'h0002);
    cfg_wr(2'd1, 16'd5);
    cfg_wr(2'd2, 16'h0300);
    clr();
    @(negedge clk); dreq = 1'b1;
    wait_xfers(3);
    dreq = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 stop on drop", n_xfer, 3);
    chk("R8 not done", int'(done), 0);
    chk("R2 bus released", int'(hreq), 1);
    dreq = 1'b1;
    repeat (20) @(negedge clk);
    dreq = 1'b0;
    chk("R8 resume total", n_xfer, 6);
    chk("R8 resume addr", int'(alog[3]), 'h303);
    chk("R8 last addr", int'(alog[5]), 'h305);
    chk("R8 tenures", n_ten, 2);
    chk("R5 tc pulses", n_tc, 1);
    chk("R5 done", int'(done), 1);
  endtask

  task automatic t_tc_and_drop();
    cfg_wr(2'd0, 16'h0002);
    cfg_wr(2'd1, 16'd0);
    cfg_wr(2'd2, 16'h0400);
    clr();
    @(negedge clk); dreq = 1'b1;
    wait_xfers(1);
    dreq = 1'b0;
    repeat (10) @(negedge clk);
    chk("R4 count zero one xfer", n_xfer, 1);
    chk("R5 tc with drop", n_tc, 1);
    chk("R5 done with drop", int'(done), 1);
    dreq = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 request ignored", n_ten, 1);
    chk("R9 no bus request", int'(hreq), 1);
    cfg_wr(2'd1, 16'd1);
    repeat (20) @(negedge clk);
    dreq = 1'b0;
    chk("R9 reload resumes", n_xfer, 3);
    chk("R8 addr kept", int'(alog[1]), 'h401);
    chk("R3 addr next", int'(alog[2]), 'h402);
    chk("R5 second tc", n_tc, 2);
  endtask

  task automatic t_wrap();
    cfg_wr(2'd0, 16'h0001);
    cfg_wr(2'd1, 16'd1);
    cfg_wr(2'd2, 16'hFFFF);
    clr();
    @(negedge clk); dreq = 1'b1;
    @(negedge clk); dreq = 1'b0;
    repeat (20) @(negedge clk);
    chk("R4 wrap count", n_xfer, 2);
    chk("R3 addr top", int'(alog[0]), 'hFFFF);
    chk("R3 addr wrap", int'(alog[1]), 0);
  endtask

  task automatic t_rsvd();
    cfg_wr(2'd0, 16'h0003);
    cfg_wr(2'd1, 16'd1);
    clr();
    @(negedge clk); dreq = 1'b1;
    repeat (30) @(negedge clk);
    dreq = 1'b0;
    chk("R1 mode 11 as single xfers", n_xfer, 2);
    chk("R1 mode 11 as single tenures", n_ten, 2);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_single();
    t_block();
    t_demand();
    t_tc_and_drop();
    t_wrap();
    t_rsvd();
    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule